// File: doc/BRIEF.md
# Dual-Bridge Phase-Shift Gate Generator

This block drives the eight switches of two full bridges that share a transformer in an isolated bidirectional DC-DC stage. A free-running carrier counter sets the switching period. Every switch toggles with a fixed 50% duty. The two legs of each bridge run in opposite phase, so each bridge produces a bipolar square wave. The whole secondary bridge is shifted against the primary by a signed phase-shift ratio, and the sign of that ratio sets the direction of power flow.

The controller feeding the block supplies the ratio as a signed fixed-point word, together with the period in clock cycles and a dead-time count. The block picks up the ratio and the period only when a new carrier period starts, so a half-cycle is never cut short or stretched. Ratios outside plus or minus one half are limited to that range. Each complementary pair gets a programmable dead time. At 100 MHz, a period of 5000 cycles gives the nominal 20 kHz switching rate.

Top module: `sps_gate_gen`

## Requirements
- R1: While `rst_n` is low (synchronous, active low), all eight gate outputs are low, whatever the other inputs are.
- R2: While `enable` is low, all gate outputs are low in that same cycle and the carrier is cleared. After `enable` rises, the carrier loads on the first clock and starts at count zero on the next clock. Gates follow the carrier with one register stage.
- R3: The carrier counts 0 to P-1, where P is `period_i` (even, at least 4). The primary leg A reference is high while the count is below P/2, so the S1 gate is high for P/2 minus the dead time in each period.
- R4: The ratio is two's complement with 2^(RATIO_W-1) standing for 1.0. The secondary shift in cycles is (ratio * P) >>> RATIO_W, rounded toward minus infinity. A positive shift delays the secondary bridge by that many cycles against the primary.
- R5: A negative ratio advances the secondary bridge against the primary by the magnitude of the shift.
- R6: Ratios above +2^(RATIO_W-2) (+0.5) or below -2^(RATIO_W-2) (-0.5) are clamped to those limits before the shift is computed. The limits themselves pass unchanged.
- R7: Ratio and period are sampled only when a carrier period starts. Changes made in mid-period take effect from the next period start.
- R8: After the reference of a leg changes, both switches of that pair stay low for exactly `deadtime_i` cycles. The two switches of a pair are never high together. A dead time of 0 gives complementary switching with no gap.
- R9: Gate bit mapping: bit 2k is the high side and bit 2k+1 the low side of leg k. Leg 0 is primary A (S1/S2), leg 1 is primary B (S3/S4), leg 2 is secondary A (S5/S6) and leg 3 is secondary B (S7/S8). Legs A and B of a bridge run in opposite phase. With a zero ratio, the secondary gates equal the primary gates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run request; low forces all gates off |
| period_i | input | CNT_W | Switching period in clock cycles |
| deadtime_i | input | DT_W | Dead time per pair transition, in cycles |
| ratio_i | input | RATIO_W | Signed phase-shift ratio, 2^(RATIO_W-1) = 1.0 |
| gate_o | output | 8 | Gate signals S1..S8 on bits 0..7 |

## Verification
The bench builds the block with an 8-bit carrier, a 4-bit dead time and a 16-bit ratio. Periods of 40 and 48 cycles then complete dozens of carrier periods in a short run, while dead times up to 7 stay well inside a half period. The full 16-bit ratio lets the clamp limits, the raw extremes 0x7FFF and 0x8000, and quarter-scale shifts of exactly five cycles all be reached. A mid-period change of period and ratio shows that the old period completes first.

// File: rtl/sps_pkg.sv
// Shared constants and types for the phase-shift gate generator.
// Assumes exactly two bridges with two legs each.
package sps_pkg;
    localparam int unsigned NUM_LEGS = 4;
    localparam int unsigned GATE_W   = 2 * NUM_LEGS;

    // Leg index order; the gate bit mapping depends on it.
    typedef enum logic [1:0] {
        LEG_PRI_A = 2'd0,
        LEG_PRI_B = 2'd1,
        LEG_SEC_A = 2'd2,
        LEG_SEC_B = 2'd3
    } leg_e;

    // One complementary switch pair.
    typedef struct packed {
        logic hi;
        logic lo;
    } gate_pair_t;
endpackage

// File: rtl/sps_carrier.sv
// Carrier counter and period-start sampler.
// Counts 0..len-1, and at each period start latches the period and the
// clamped phase shift in cycles. Assumes period_i is even and >= 4.
module sps_carrier #(
    parameter int CNT_W   = 16,
    parameter int RATIO_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enable,
    input  logic [CNT_W-1:0]          period_i,
    input  logic signed [RATIO_W-1:0] ratio_i,
    output logic                      run_o,
    output logic [CNT_W-1:0]          cnt_o,
    output logic [CNT_W-1:0]          len_o,
    output logic signed [CNT_W:0]     shift_o
);
    localparam int SH_W   = CNT_W + 1;
    localparam int PROD_W = RATIO_W + CNT_W + 1;
    localparam logic signed [RATIO_W-1:0] R_POS = {2'b01, {(RATIO_W-2){1'b0}}};
    localparam logic signed [RATIO_W-1:0] R_NEG = {2'b11, {(RATIO_W-2){1'b0}}};

    logic                      run_q;
    logic [CNT_W-1:0]          cnt_q;
    logic [CNT_W-1:0]          len_q;
    logic signed [SH_W-1:0]    shift_q;
    logic signed [RATIO_W-1:0] ratio_c;
    logic signed [PROD_W-1:0]  prod;
    logic signed [SH_W-1:0]    shift_d;

    // Clamp the ratio to +/-0.5 and scale it by the period.
    always_comb begin
        if (ratio_i > R_POS)
            ratio_c = R_POS;
        else if (ratio_i < R_NEG)
            ratio_c = R_NEG;
        else
            ratio_c = ratio_i;
        prod    = ratio_c * $signed({1'b0, period_i});
        shift_d = SH_W'(prod >>> RATIO_W);
    end

    // Restart when idle, load at period start, otherwise count.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            run_q   <= 1'b0;
            cnt_q   <= '0;
            len_q   <= '0;
            shift_q <= '0;
        end else if (!run_q || cnt_q == len_q - 1'b1) begin
            run_q   <= 1'b1;
            cnt_q   <= '0;
            len_q   <= period_i;
            shift_q <= shift_d;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign run_o   = run_q;
    assign cnt_o   = cnt_q;
    assign len_o   = len_q;
    assign shift_o = shift_q;
endmodule

// File: rtl/sps_phase.sv
// Leg reference generator.
// Primary legs follow the carrier. Secondary legs follow the carrier
// displaced by the signed shift, wrapped into 0..len-1. All references
// are low while the carrier is not running.
module sps_phase import sps_pkg::*; #(
    parameter int CNT_W = 16
) (
    input  logic                  run_i,
    input  logic [CNT_W-1:0]      cnt_i,
    input  logic [CNT_W-1:0]      len_i,
    input  logic signed [CNT_W:0] shift_i,
    output logic [NUM_LEGS-1:0]   ref_o
);
    localparam int SC_W = CNT_W + 2;

    logic [CNT_W-1:0]       half;
    logic signed [SC_W-1:0] len_s;
    logic signed [SC_W-1:0] half_s;
    logic signed [SC_W-1:0] sc;
    logic                   pri;
    logic                   sec;

    // Wrap the displaced count and compare both counts with the half period.
    always_comb begin
        half   = len_i >> 1;
        len_s  = $signed({2'b00, len_i});
        half_s = $signed({2'b00, half});
        sc     = $signed({2'b00, cnt_i}) - SC_W'(shift_i);
        if (sc < 0)
            sc = sc + len_s;
        else if (sc >= len_s)
            sc = sc - len_s;
        pri = cnt_i < half;
        sec = sc < half_s;
        ref_o            = '0;
        ref_o[LEG_PRI_A] = run_i & pri;
        ref_o[LEG_PRI_B] = run_i & ~pri;
        ref_o[LEG_SEC_A] = run_i & sec;
        ref_o[LEG_SEC_B] = run_i & ~sec;
    end
endmodule

// File: rtl/sps_deadband.sv
// Dead-time unit for one complementary pair.
// Registers the leg reference and counts the cycles since its last change.
// A switch turns on only after the count reaches the dead time.
// Assumes the dead time is shorter than a half period.
module sps_deadband import sps_pkg::*; #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            ref_i,
    input  logic [DT_W-1:0] dt_i,
    output gate_pair_t      pair_o
);
    logic            lvl_q;
    logic [DT_W-1:0] age_q;
    logic            settled;

    // Track the reference level and the cycles since it last changed.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            lvl_q <= 1'b0;
            age_q <= '0;
        end else if (ref_i != lvl_q) begin
            lvl_q <= ref_i;
            age_q <= '0;
        end else if (age_q < dt_i) begin
            age_q <= age_q + 1'b1;
        end
    end

    // Drive one side once the dead time has passed, never while idle.
    always_comb begin
        settled   = age_q >= dt_i;
        pair_o.hi = rst_n & enable & lvl_q & settled;
        pair_o.lo = rst_n & enable & ~lvl_q & settled;
    end
endmodule

// File: rtl/sps_gate_gen.sv
// Single phase-shift gate generator for two full bridges.
// Shares one carrier between both bridges and feeds four leg references
// through per-pair dead-time units. Gate bit 2k is the high side and bit
// 2k+1 the low side of leg k.
module sps_gate_gen import sps_pkg::*; #(
    parameter int CNT_W   = 16,
    parameter int RATIO_W = 16,
    parameter int DT_W    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enable,
    input  logic [CNT_W-1:0]          period_i,
    input  logic [DT_W-1:0]           deadtime_i,
    input  logic signed [RATIO_W-1:0] ratio_i,
    output logic [GATE_W-1:0]         gate_o
);
    localparam int SH_W = CNT_W + 1;

    logic                   run_w;
    logic [CNT_W-1:0]       cnt_w;
    logic [CNT_W-1:0]       len_w;
    logic signed [SH_W-1:0] shift_w;
    logic [NUM_LEGS-1:0]    ref_w;
    gate_pair_t             pair_w [NUM_LEGS];

    sps_carrier #(.CNT_W(CNT_W), .RATIO_W(RATIO_W)) u_carrier (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .period_i (period_i),
        .ratio_i  (ratio_i),
        .run_o    (run_w),
        .cnt_o    (cnt_w),
        .len_o    (len_w),
        .shift_o  (shift_w)
    );

    sps_phase #(.CNT_W(CNT_W)) u_phase (
        .run_i   (run_w),
        .cnt_i   (cnt_w),
        .len_i   (len_w),
        .shift_i (shift_w),
        .ref_o   (ref_w)
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        sps_deadband #(.DT_W(DT_W)) u_db (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (enable),
            .ref_i  (ref_w[g]),
            .dt_i   (deadtime_i),
            .pair_o (pair_w[g])
        );
        assign gate_o[2*g]   = pair_w[g].hi;
        assign gate_o[2*g+1] = pair_w[g].lo;
    end
endmodule

// File: rtl/sps_gate_gen_chk.sv
// Property checker for sps_gate_gen, attached through bind.
// Observes the gate port and the carrier state between the sub-blocks.
module sps_gate_gen_chk #(
    parameter int CNT_W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  enable,
    input logic [7:0]            gate_o,
    input logic                  run_i,
    input logic [CNT_W-1:0]      cnt_i,
    input logic [CNT_W-1:0]      len_i,
    input logic signed [CNT_W:0] shift_i
);
    localparam int SC_W = CNT_W + 2;

    logic signed [SC_W-1:0] quarter_s;
    logic signed [SC_W-1:0] shift_x;

    // Quarter period rounded up, and the shift at the same width.
    always_comb begin
        quarter_s = ($signed({2'b00, len_i}) + SC_W'(3)) >>> 2;
        shift_x   = SC_W'(shift_i);
    end

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (gate_o & 8'h55) == 8'h00);

    p_idle_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (gate_o & 8'h55) == 8'h00);

    p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> cnt_i < len_i);

    p_shift_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (shift_x <= quarter_s) && (shift_x >= -quarter_s));

    p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && cnt_i != '0) |-> ($stable(len_i) && $stable(shift_i)));

    for (genvar k = 0; k < 4; k++) begin : g_pair
        p_pair_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !(gate_o[2*k] && gate_o[2*k+1]));
    end

    p_pri_opposite_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o[0] |-> !gate_o[2]);

    p_sec_opposite_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o[4] |-> !gate_o[6]);
endmodule

bind sps_gate_gen sps_gate_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .gate_o  (gate_o),
    .run_i   (run_w),
    .cnt_i   (cnt_w),
    .len_i   (len_w),
    .shift_i (shift_w)
);

// File: tb/sps_gate_gen_bench.sv
// Scoreboard bench: a model process queues the expected gate word after
// each clock edge, and a monitor pops and compares it at the falling edge.
module sps_gate_gen_bench;
    localparam int CW = 8;
    localparam int RW = 16;
    localparam int DW = 4;

    logic                 clk      = 1'b0;
    logic                 rst_n    = 1'b0;
    logic                 enable   = 1'b0;
    logic [CW-1:0]        period   = 8'd40;
    logic [DW-1:0]        deadtime = 4'd3;
    logic signed [RW-1:0] ratio    = '0;
    logic [7:0]           gate;

    int    n_chk = 0;
    int    n_err = 0;
    int    cyc   = 0;
    bit    done  = 1'b0;
    string scen  = "R1";
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    sps_gate_gen #(.CNT_W(CW), .RATIO_W(RW), .DT_W(DW)) u_sps_gate_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .period_i   (period),
        .deadtime_i (deadtime),
        .ratio_i    (ratio),
        .gate_o     (gate)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int clamp_ratio(input int r);
        if (r > 16384) return 16384;
        if (r < -16384) return -16384;
        return r;
    endfunction

    // Reference model state, built from the requirements
    int m_run = 0, m_cnt = 0, m_len = 0, m_sh = 0;
    int m_r[4] = '{0, 0, 0, 0};
    int m_age[4] = '{0, 0, 0, 0};

    always @(posedge clk) cyc++;

    // Model: advance one clock and queue the expected gate word
    always @(posedge clk) begin : model
        int refs[4];
        int half, sc;
        logic [7:0] e;
        if (!rst_n || !enable) begin
            m_run = 0; m_cnt = 0; m_sh = 0;
            for (int k = 0; k < 4; k++) begin m_r[k] = 0; m_age[k] = 0; end
        end else begin
            half = m_len / 2;
            sc = m_cnt - m_sh;
            if (sc < 0) sc += m_len;
            else if (sc >= m_len) sc -= m_len;
            refs[0] = (m_run != 0 && m_cnt < half) ? 1 : 0;
            refs[1] = (m_run != 0 && m_cnt >= half) ? 1 : 0;
            refs[2] = (m_run != 0 && sc < half) ? 1 : 0;
            refs[3] = (m_run != 0 && sc >= half) ? 1 : 0;
            for (int k = 0; k < 4; k++) begin
                if (refs[k] != m_r[k]) begin m_r[k] = refs[k]; m_age[k] = 0; end
                else if (m_age[k] < int'(deadtime)) m_age[k]++;
            end
            if (m_run == 0 || m_cnt == m_len - 1) begin
                m_run = 1; m_cnt = 0; m_len = int'(period);
                m_sh = int'((longint'(clamp_ratio(int'(ratio))) * longint'(m_len)) >>> 16);
            end else begin
                m_cnt++;
            end
        end
        for (int k = 0; k < 4; k++) begin
            e[2*k]   = rst_n && enable && m_r[k] != 0 && m_age[k] >= int'(deadtime);
            e[2*k+1] = rst_n && enable && m_r[k] == 0 && m_age[k] >= int'(deadtime);
        end
        exp_q.push_back(e);
    end

    // Monitor: compare the design output with the queued expectation
    always @(negedge clk) begin
        if (exp_q.size() > 0 && !done) begin : mon
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(gate === e, {scen, " gate word"}, int'(gate), int'(e));
        end
    end

    task automatic drive_gap();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic next_rise(input int b, output int t);
        logic prev;
        prev = gate[b];
        t = -1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!prev && gate[b]) begin t = cyc; break; end
            prev = gate[b];
        end
    endtask

    task automatic rise_gap(input int a, input int b, output int gap);
        int ta, tb;
        next_rise(a, ta);
        next_rise(b, tb);
        gap = tb - ta;
    endtask

    task automatic count_high(input int b, input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (gate[b]) c++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog R1..all actual=running expected=finished");
        finish_run();
    end

    initial begin
        int g, c, t0, t1;
        // R1: reset with enable high and dead time set keeps all gates low
        drive_gap();
        enable = 1'b1;
        wait_cyc(4);
        chk(gate == 8'h00, "R1 gates in reset", int'(gate), 0);

        // R3 R9: zero ratio, period 40, dead time 3
        drive_gap();
        scen = "R3 R9";
        rst_n = 1'b1;
        wait_cyc(120);
        rise_gap(0, 0, g);
        chk(g == 40, "R3 carrier period", g, 40);
        count_high(0, 40, c);
        chk(c == 17, "R3 S1 high cycles", c, 17);
        c = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (gate[2] != gate[1] || gate[3] != gate[0] || gate[7:4] != gate[3:0]) c++;
        end
        chk(c == 0, "R9 leg mapping and opposite phase", c, 0);

        // R4: +0.25 delays the secondary by 5 cycles
        drive_gap();
        scen = "R4";
        ratio = 16'sh2000;
        wait_cyc(100);
        rise_gap(0, 4, g);
        chk(g == 5, "R4 secondary lag", g, 5);

        // R5: -0.25 advances the secondary by 5 cycles
        drive_gap();
        scen = "R5";
        ratio = -16'sh2000;
        wait_cyc(100);
        rise_gap(4, 0, g);
        chk(g == 5, "R5 secondary lead", g, 5);

        // R6: clamp limits and raw extremes
        drive_gap();
        scen = "R6";
        ratio = 16'sh4000;
        wait_cyc(100);
        rise_gap(0, 4, g);
        chk(g == 10, "R6 limit +0.5 lag", g, 10);
        drive_gap();
        ratio = 16'sh7FFF;
        wait_cyc(100);
        rise_gap(0, 4, g);
        chk(g == 10, "R6 clamp high lag", g, 10);
        drive_gap();
        ratio = 16'sh8000;
        wait_cyc(100);
        rise_gap(4, 0, g);
        chk(g == 10, "R6 clamp low lead", g, 10);

        // R7: mid-period change completes the running period first
        drive_gap();
        scen = "R7";
        ratio = '0;
        wait_cyc(100);
        next_rise(0, t0);
        wait_cyc(10);
        drive_gap();
        period = 8'd48;
        ratio = 16'sh2000;
        next_rise(0, t1);
        chk(t1 - t0 == 40, "R7 old period kept", t1 - t0, 40);
        rise_gap(0, 0, g);
        chk(g == 48, "R7 new period", g, 48);

        // R8: dead time 7 and 0 on a 48-cycle period
        drive_gap();
        scen = "R8";
        ratio = '0;
        deadtime = 4'd7;
        wait_cyc(100);
        c = 0;
        for (int i = 0; i < 48; i++) begin
            @(negedge clk);
            if (!gate[0] && !gate[1]) c++;
        end
        chk(c == 14, "R8 gap cycles dt=7", c, 14);
        drive_gap();
        deadtime = 4'd0;
        wait_cyc(100);
        c = 0;
        for (int i = 0; i < 48; i++) begin
            @(negedge clk);
            if (!gate[0] && !gate[1]) c++;
        end
        chk(c == 0, "R8 gap cycles dt=0", c, 0);

        // R2: disable forces gates low, restart timing afterwards
        drive_gap();
        scen = "R2";
        deadtime = 4'd2;
        wait_cyc(100);
        drive_gap();
        enable = 1'b0;
        for (int i = 0; i < 6; i++) begin
            #2;
            chk(gate == 8'h00, "R2 gates while disabled", int'(gate), 0);
            @(negedge clk);
        end
        #1;
        enable = 1'b1;
        t0 = cyc;
        next_rise(0, t1);
        chk(t1 - t0 == 4, "R2 first S1 rise after enable", t1 - t0, 4);
        wait_cyc(60);
        finish_run();
    end
endmodule